// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block watches the command stream that a memory controller issues to a multi-bank DRAM and keeps a model of each bank's state. It also models the device-wide busy periods. Each cycle it takes one command, an auto-precharge flag and a bank address. It judges the command against the state of the addressed bank, or against the whole device for device-wide commands. A legal command moves the model forward. A command that is not legal for the current state leaves the model untouched and raises a flag for one cycle.

Each bank has a down-counter for its transient states. These are row activation, precharge, plain bursts and auto-precharge bursts. One further device-wide counter covers refresh, mode-register access and precharge-all. During those device-wide periods only NOP is accepted. All timings are parameters counted in clock cycles: activate-to-active delay, precharge time, refresh cycle time, mode-register delay and burst length. A typical use is as a protocol monitor beside a controller, or as the legality gate inside one.

Top module: `dram_bank_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bank reads Idle, the device reads Ready and the illegal flag is low. Bank state codes (3 bits per bank, bank i at bits 3i+2..3i): Idle 0, Activating 1, Active 2, Read 3, Write 4, Precharging 5, Read with auto-precharge 6, Write with auto-precharge 7. Device codes: Ready 0, Refreshing 1, ModeSet 2, PrechargeAll 3.
- R2: Command codes are NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE 4, PRECHARGE ALL 5, AUTO REFRESH 6, MODE REGISTER SET 7. An ACTIVE to an Idle bank makes it Activating for T_RCD cycles, after which it is Active.
- R3: A READ or WRITE with the auto-precharge flag low, sent to an Active bank, makes it Read or Write for BURST_LEN cycles, after which it is Active again.
- R4: A READ or WRITE with the auto-precharge flag high, sent to an Active bank, makes it Read-AP or Write-AP for BURST_LEN+T_RP cycles, after which it is Idle.
- R5: A PRECHARGE to an Active bank makes it Precharging for T_RP cycles, after which it is Idle. A PRECHARGE to a bank in any other state is illegal.
- R6: A bank command (ACTIVE, READ, WRITE, PRECHARGE) is illegal when the addressed bank is in any state other than the one R2, R3 or R5 names for it. This includes a WRITE while that bank's read burst is running. Commands to other banks are judged by their own states only.
- R7: AUTO REFRESH is legal only when the device is Ready and every bank is Idle. It puts the device in Refreshing for T_RC cycles, and the device then returns to Ready.
- R8: MODE REGISTER SET has the same legality as refresh. It puts the device in ModeSet for T_MRD cycles, and the device then returns to Ready.
- R9: PRECHARGE ALL is legal only when the device is Ready and every bank is Idle or Active. It puts every bank in Precharging and the device in PrechargeAll for T_RP cycles, after which all banks are Idle and the device is Ready.
- R10: While the device is not Ready, any command other than NOP is illegal, whatever bank it addresses.
- R11: An illegal command changes no state. The flag is high in the cycle after the clock edge that registered that command, and it is low again after the next edge if that edge registered a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code registered at each rising edge |
| autoPre | input | 1 | Auto-precharge request for READ and WRITE |
| bankAddr | input | BANK_W | Target bank of a bank command |
| bankState | output | 3*NUM_BANKS | Packed state code of every bank |
| devState | output | 2 | Device-wide state code |
| illegalCmd | output | 1 | High for the cycle after an illegal command |

## Verification
The assertions assume that the command inputs are stable and known at every rising edge after reset. They also assume that the bank address of a bank command is below NUM_BANKS, because out-of-range addresses are never judged legal. The bench drives every input at the falling edge, and its bank addresses use only the four banks that exist. The checks that look back one cycle are held off for the first edge after reset, so they never see the values from before the stimulus began.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_PREALL, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE, BK_ACTIVATING, BK_ACTIVE, BK_READ, BK_WRITE,
    BK_PRECHARGING, BK_READ_AP, BK_WRITE_AP
  } bank_e;

  typedef enum logic [1:0] {
    DEV_READY, DEV_REFRESH, DEV_MODESET, DEV_PREALL
  } dev_e;

  // strobes from legality control to the state datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic autoPre;
    logic pre;
    logic preAll;
    logic refresh;
    logic modeSet;
    logic illegal;
  } strobe_t;

endpackage

// File: rtl/dbt_control.sv
module dbt_control
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [2:0]             cmd,
  input  logic                   autoPre,
  input  logic [BANK_W-1:0]      bankAddr,
  input  logic [3*NUM_BANKS-1:0] bankStates,
  input  logic                   devReady,
  output strobe_t                stb
);

  bank_e tgtState;
  logic  tgtValid;
  logic  allIdle;
  logic  allPreOk;
  logic  legal;
  cmd_e  cmdType;

  assign cmdType = cmd_e'(cmd);

  always_comb begin
    tgtState = BK_IDLE;
    tgtValid = 1'b0;
    allIdle  = 1'b1;
    allPreOk = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bankAddr == BANK_W'(i)) begin
        tgtState = bank_e'(bankStates[3*i +: 3]);
        tgtValid = 1'b1;
      end
      if (bank_e'(bankStates[3*i +: 3]) != BK_IDLE) allIdle = 1'b0;
      if (bank_e'(bankStates[3*i +: 3]) != BK_IDLE &&
          bank_e'(bankStates[3*i +: 3]) != BK_ACTIVE) allPreOk = 1'b0;
    end
  end

  always_comb begin
    unique case (cmdType)
      CMD_NOP:            legal = 1'b1;
      CMD_ACT:            legal = devReady && tgtValid && tgtState == BK_IDLE;
      CMD_RD, CMD_WR,
      CMD_PRE:            legal = devReady && tgtValid && tgtState == BK_ACTIVE;
      CMD_PREALL:         legal = devReady && allPreOk;
      CMD_REF, CMD_MRS:   legal = devReady && allIdle;
      default:            legal = 1'b0;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.autoPre = autoPre;
    stb.illegal = (cmdType != CMD_NOP) && !legal;
    if (legal) begin
      stb.act     = (cmdType == CMD_ACT);
      stb.rd      = (cmdType == CMD_RD);
      stb.wr      = (cmdType == CMD_WR);
      stb.pre     = (cmdType == CMD_PRE);
      stb.preAll  = (cmdType == CMD_PREALL);
      stb.refresh = (cmdType == CMD_REF);
      stb.modeSet = (cmdType == CMD_MRS);
    end
  end

endmodule

// File: rtl/dbt_datapath.sv
module dbt_datapath
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 5,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                stb,
  input  logic [BANK_W-1:0]      bankAddr,
  output logic [3*NUM_BANKS-1:0] bankStates,
  output dev_e                   devState,
  output logic                   illegalFlag
);

  localparam int AP_LEN = BURST_LEN + T_RP;
  localparam int MAX_A  = (T_RCD > T_MRD) ? T_RCD : T_MRD;
  localparam int MAX_B  = (AP_LEN > T_RC) ? AP_LEN : T_RC;
  localparam int MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_V + 1);

  function automatic bank_e settle(input bank_e s);
    case (s)
      BK_ACTIVATING, BK_READ, BK_WRITE: settle = BK_ACTIVE;
      default:                          settle = BK_IDLE;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_e         bankSt;
    logic [CW-1:0] bankCnt;
    logic          bankSel;

    assign bankSel = (bankAddr == BANK_W'(g));
    assign bankStates[3*g +: 3] = bankSt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bankSt  <= BK_IDLE;
        bankCnt <= '0;
      end else if (stb.preAll) begin
        bankSt  <= BK_PRECHARGING;
        bankCnt <= CW'(T_RP);
      end else if (bankSel && stb.act) begin
        bankSt  <= BK_ACTIVATING;
        bankCnt <= CW'(T_RCD);
      end else if (bankSel && stb.rd) begin
        bankSt  <= stb.autoPre ? BK_READ_AP : BK_READ;
        bankCnt <= stb.autoPre ? CW'(AP_LEN) : CW'(BURST_LEN);
      end else if (bankSel && stb.wr) begin
        bankSt  <= stb.autoPre ? BK_WRITE_AP : BK_WRITE;
        bankCnt <= stb.autoPre ? CW'(AP_LEN) : CW'(BURST_LEN);
      end else if (bankSel && stb.pre) begin
        bankSt  <= BK_PRECHARGING;
        bankCnt <= CW'(T_RP);
      end else if (bankCnt != '0) begin
        if (bankCnt == CW'(1)) bankSt <= settle(bankSt);
        bankCnt <= bankCnt - CW'(1);
      end
    end
  end

  logic [CW-1:0] devCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devState <= DEV_READY;
      devCnt   <= '0;
    end else if (stb.refresh) begin
      devState <= DEV_REFRESH;
      devCnt   <= CW'(T_RC);
    end else if (stb.modeSet) begin
      devState <= DEV_MODESET;
      devCnt   <= CW'(T_MRD);
    end else if (stb.preAll) begin
      devState <= DEV_PREALL;
      devCnt   <= CW'(T_RP);
    end else if (devCnt != '0) begin
      if (devCnt == CW'(1)) devState <= DEV_READY;
      devCnt <= devCnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegalFlag <= 1'b0;
    else        illegalFlag <= stb.illegal;
  end

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 5,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd,
  input  logic                   autoPre,
  input  logic [BANK_W-1:0]      bankAddr,
  output logic [3*NUM_BANKS-1:0] bankState,
  output logic [1:0]             devState,
  output logic                   illegalCmd
);

  strobe_t stb;
  dev_e    devSt;

  assign devState = devSt;

  dbt_control #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ctrl (
    .cmd        (cmd),
    .autoPre    (autoPre),
    .bankAddr   (bankAddr),
    .bankStates (bankState),
    .devReady   (devSt == DEV_READY),
    .stb        (stb)
  );

  dbt_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .BURST_LEN(BURST_LEN)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .bankAddr    (bankAddr),
    .bankStates  (bankState),
    .devState    (devSt),
    .illegalFlag (illegalCmd)
  );

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             cmd,
  input logic [BANK_W-1:0]      bankAddr,
  input logic [3*NUM_BANKS-1:0] bankState,
  input logic [1:0]             devState,
  input logic                   illegalCmd
);

  logic pastValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  function automatic logic [2:0] stOf(input logic [3*NUM_BANKS-1:0] v,
                                      input logic [BANK_W-1:0] b);
    stOf = 3'd0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (b == BANK_W'(i)) stOf = v[3*i +: 3];
  endfunction

  AST_FLAG_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    illegalCmd |-> $past(cmd) != 3'(CMD_NOP)); // R11

  AST_DEV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    ($past(devState) != 2'(DEV_READY) && $past(cmd) != 3'(CMD_NOP)) |-> illegalCmd); // R10

  AST_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    (!illegalCmd && $past(cmd) == 3'(CMD_ACT)) |->
      ($past(stOf(bankState, bankAddr)) == 3'(BK_IDLE) &&
       stOf(bankState, $past(bankAddr)) == 3'(BK_ACTIVATING))); // R2

  AST_REF_ENTERS: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    (!illegalCmd && $past(cmd) == 3'(CMD_REF)) |-> devState == 2'(DEV_REFRESH)); // R7

  AST_MRS_ENTERS: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    (!illegalCmd && $past(cmd) == 3'(CMD_MRS)) |-> devState == 2'(DEV_MODESET)); // R8

  AST_PREALL_ENTERS: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
    (!illegalCmd && $past(cmd) == 3'(CMD_PREALL)) |-> devState == 2'(DEV_PREALL)); // R9

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n || !pastValid)
      $past(bankState[3*g +: 3]) == 3'(BK_IDLE) |->
        (bankState[3*g +: 3] == 3'(BK_IDLE) ||
         bankState[3*g +: 3] == 3'(BK_ACTIVATING) ||
         bankState[3*g +: 3] == 3'(BK_PRECHARGING))); // R6
  end

endmodule

bind dram_bank_tracker dbt_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .bankAddr   (bankAddr),
  .bankState  (bankState),
  .devState   (devState),
  .illegalCmd (illegalCmd)
);

// File: tb/dram_bank_tracker_tb.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic          autoPre = 1'b0;
  logic [1:0]    bankAddr = 2'd0;
  logic [3*NB-1:0] bankState;
  logic [1:0]    devState;
  logic          illegalCmd;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_bank_tracker #(.NUM_BANKS(NB), .T_RCD(2), .T_RP(3), .T_RC(5), .T_MRD(2),
                      .BURST_LEN(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .autoPre(autoPre), .bankAddr(bankAddr),
    .bankState(bankState), .devState(devState), .illegalCmd(illegalCmd)
  );

  typedef struct packed {
    logic [2:0] c;
    logic       ap;
    logic [1:0] b;
    logic       flag;
    logic [2:0] st0;
    logic [1:0] dev;
  } vec_t;

  // cmd, ap, bank, expected flag, expected bank0 state, expected device state
  localparam vec_t VEC [31] = '{
    '{3'd1, 1'b0, 2'd0, 1'b0, 3'd1, 2'd0},  // R2 ACT b0
    '{3'd2, 1'b0, 2'd0, 1'b1, 3'd1, 2'd0},  // R6 READ while activating
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd2, 2'd0},  // R2 active after T_RCD
    '{3'd2, 1'b0, 2'd0, 1'b0, 3'd3, 2'd0},  // R3 READ
    '{3'd3, 1'b0, 2'd0, 1'b1, 3'd3, 2'd0},  // R6 WRITE during read burst
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd2, 2'd0},  // R3 back to active
    '{3'd3, 1'b0, 2'd0, 1'b0, 3'd4, 2'd0},  // R3 WRITE
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd4, 2'd0},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd2, 2'd0},  // R3
    '{3'd4, 1'b0, 2'd0, 1'b0, 3'd5, 2'd0},  // R5 PRE
    '{3'd1, 1'b0, 2'd0, 1'b1, 3'd5, 2'd0},  // R6 ACT while precharging
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd5, 2'd0},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0},  // R5 idle after T_RP
    '{3'd6, 1'b0, 2'd0, 1'b0, 3'd0, 2'd1},  // R7 REF
    '{3'd1, 1'b0, 2'd3, 1'b1, 3'd0, 2'd1},  // R10 ACT other bank blocked
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd1},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd1},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd1},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0},  // R7 ready after T_RC
    '{3'd7, 1'b0, 2'd0, 1'b0, 3'd0, 2'd2},  // R8 MRS
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd2},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0},  // R8 ready after T_MRD
    '{3'd4, 1'b0, 2'd0, 1'b1, 3'd0, 2'd0},  // R5 PRE to idle bank
    '{3'd2, 1'b0, 2'd0, 1'b1, 3'd0, 2'd0},  // R6 READ to idle bank
    '{3'd1, 1'b0, 2'd1, 1'b0, 3'd0, 2'd0},  // R6 ACT b1, b0 untouched
    '{3'd6, 1'b0, 2'd0, 1'b1, 3'd0, 2'd0},  // R7 REF with bank busy
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0},
    '{3'd5, 1'b0, 2'd0, 1'b0, 3'd5, 2'd3},  // R9 PREALL
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd5, 2'd3},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd5, 2'd3},
    '{3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 2'd0}   // R9 all idle after T_RP
  };

  function automatic logic [2:0] bankOf(input int i);
    return bankState[3*i +: 3];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic ap, input logic [1:0] b);
    cmd = c; autoPre = ap; bankAddr = b;
    @(posedge clk);
    @(negedge clk);
    cmd = 3'd0; autoPre = 1'b0; bankAddr = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NB; i++) check("R1", "bank state in reset", int'(bankOf(i)), 0);
    check("R1", "device state in reset", int'(devState), 0);
    check("R1", "flag in reset", int'(illegalCmd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "device after reset", int'(devState), 0);

    for (int v = 0; v < 31; v++) begin
      step(VEC[v].c, VEC[v].ap, VEC[v].b);
      check("R2-table", $sformatf("vec %0d flag", v), int'(illegalCmd), int'(VEC[v].flag));
      check("R3-table", $sformatf("vec %0d bank0", v), int'(bankOf(0)), int'(VEC[v].st0));
      check("R7-table", $sformatf("vec %0d device", v), int'(devState), int'(VEC[v].dev));
    end
    check("R9", "bank1 idle after precharge all", int'(bankOf(1)), 0);

    // R4 read with auto-precharge on bank 2, plus R11 one-cycle flag
    step(3'd1, 1'b0, 2'd2);
    step(3'd1, 1'b0, 2'd2);
    check("R11", "flag on illegal ACT", int'(illegalCmd), 1);
    check("R11", "illegal ACT keeps activating", int'(bankOf(2)), 1);
    step(3'd0, 1'b0, 2'd0);
    check("R11", "flag drops after NOP", int'(illegalCmd), 0);
    check("R2", "bank2 active", int'(bankOf(2)), 2);
    step(3'd2, 1'b1, 2'd2);
    check("R4", "read-AP entered", int'(bankOf(2)), 6);
    repeat (4) step(3'd0, 1'b0, 2'd0);
    check("R4", "read-AP still busy", int'(bankOf(2)), 6);
    step(3'd0, 1'b0, 2'd0);
    check("R4", "idle after read-AP", int'(bankOf(2)), 0);

    // R4 write with auto-precharge on bank 3, R6 blocked during it
    step(3'd1, 1'b0, 2'd3);
    step(3'd0, 1'b0, 2'd0);
    step(3'd0, 1'b0, 2'd0);
    step(3'd3, 1'b1, 2'd3);
    check("R4", "write-AP entered", int'(bankOf(3)), 7);
    step(3'd4, 1'b0, 2'd3);
    check("R6", "PRE during write-AP flagged", int'(illegalCmd), 1);
    check("R6", "PRE during write-AP ignored", int'(bankOf(3)), 7);
    step(3'd5, 1'b0, 2'd0);
    check("R9", "PREALL with bank busy flagged", int'(illegalCmd), 1);
    check("R9", "PREALL with bank busy ignored", int'(devState), 0);
    repeat (2) step(3'd0, 1'b0, 2'd0);
    check("R4", "write-AP still busy", int'(bankOf(3)), 7);
    step(3'd0, 1'b0, 2'd0);
    check("R4", "idle after write-AP", int'(bankOf(3)), 0);

    // R1 reset in mid operation
    step(3'd1, 1'b0, 2'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset clears activating bank", int'(bankOf(1)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "flag low after reset", int'(illegalCmd), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule